// File: doc/BRIEF.md
# Two-Phase Overload Blanking Timer

This block holds off an overload protection action so that brief power peaks do not shut the converter down. When the overload flag rises, a built-in digital delay runs first. If the overload persists past that delay, the block starts a relaxation oscillation on an external capacitor. It closes a charge switch until an upper-threshold comparator reports, then a discharge switch until a lower-threshold comparator reports, and repeats. Each completed charge half counts one oscillation. After a set number of oscillations it raises a level trip output for the protection sequencer. A larger external capacitor therefore stretches the total blanking time without any change to the logic.

If the overload flag drops at any point, the block returns to idle with the count cleared. A guard counter limits each charge or discharge half, so a missing or open capacitor cannot leave the timer hung. When the guard expires, the block raises an error level instead of tripping.

States: `ST_IDLE` (waiting), `ST_FIXED` (built-in delay), `ST_CHARGE`, `ST_DISCHARGE`, `ST_TRIP` (trip held), `ST_STUCK` (guard expired). Transitions: idle→fixed on overload; fixed→charge when the delay ends; charge→discharge on the upper flag; charge→trip on the upper flag that completes the last oscillation; discharge→charge on the lower flag; charge or discharge→stuck on guard expiry; any non-idle state→idle when the overload flag is low.

Top module: `ovl_blank_timer`

## Requirements
- R1: After reset, and in idle, all four outputs (`chg_on_o`, `dis_on_o`, `trip_o`, `tmo_err_o`) are low.
- R2: After `ovld_i` is first seen high in idle, both switches stay off for exactly `PH1_CYCLES` clock cycles. `chg_on_o` rises on the next cycle.
- R3: `chg_on_o` stays high until `cap_hi_i` is seen high in a cycle where it is on. That event counts one oscillation, and `dis_on_o` turns on the following cycle (unless R5 applies).
- R4: `dis_on_o` stays high until `cap_lo_i` is seen high in a cycle where it is on. `chg_on_o` turns on the following cycle.
- R5: The `NUM_OSC`-th counted oscillation (default 256) raises `trip_o` the following cycle, with both switches off.
- R6: `chg_on_o` and `dis_on_o` are never high together.
- R7: When `ovld_i` is seen low in any state, the next cycle has all outputs low. The oscillation count is cleared, so a new overload repeats the whole R2 delay and all `NUM_OSC` oscillations.
- R8: `trip_o` remains high for as long as `ovld_i` stays high.
- R9: A charge or discharge half that lasts `TMO_CYCLES` cycles without its comparator flag ends in the error state. `tmo_err_o` is high, both switches are off and `trip_o` is low; the error is held while `ovld_i` stays high.
- R10: The comparator flags have no effect outside their own half: `cap_hi_i` is ignored except during charge, and `cap_lo_i` except during discharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovld_i | input | 1 | Overload flag (feedback above the overload level) |
| cap_hi_i | input | 1 | Capacitor reached upper threshold |
| cap_lo_i | input | 1 | Capacitor reached lower threshold |
| chg_on_o | output | 1 | Charge switch control |
| dis_on_o | output | 1 | Discharge switch control |
| trip_o | output | 1 | Protection trigger, level |
| tmo_err_o | output | 1 | Guard timeout error, level |

## Verification
The assertions assume that `ovld_i`, `cap_hi_i` and `cap_lo_i` are synchronous to `clk` and settle well before each rising edge. They also assume that the comparator flags are the only route by which a charge or discharge half ends before the guard expires. The bench drives every input on the falling edge. It models the capacitor as an integer level that ramps by a chosen step while a switch is on, and derives both flags from that level. The same flags can also be held stuck or forced high, to reach the timeout paths and the ignored-flag cases.

// File: rtl/ovl_blank_pkg.sv
package ovl_blank_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_FIXED     = 3'd1,
        ST_CHARGE    = 3'd2,
        ST_DISCHARGE = 3'd3,
        ST_TRIP      = 3'd4,
        ST_STUCK     = 3'd5
    } blank_state_e;

endpackage

// File: rtl/ovl_fixed_delay.sv
// Counts the cycles spent in the built-in delay; flags the final one.
module ovl_fixed_delay #(
    parameter int PH1_CYCLES = 4_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);
    localparam int FIX_W = (PH1_CYCLES > 1) ? $clog2(PH1_CYCLES) : 1;
    localparam logic [FIX_W-1:0] FIX_LAST = FIX_W'(PH1_CYCLES - 1);

    logic [FIX_W-1:0] elapsed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed_q <= '0;
        end else if (!run_i) begin
            elapsed_q <= '0;
        end else if (elapsed_q != FIX_LAST) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    assign last_o = run_i && (elapsed_q == FIX_LAST);
endmodule

// File: rtl/ovl_osc_counter.sv
// Counts completed charge halves; flags when the next one is the last.
module ovl_osc_counter #(
    parameter int NUM_OSC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic inc_i,
    output logic final_o
);
    localparam int CNT_W = $clog2(NUM_OSC + 1);
    localparam logic [CNT_W-1:0] CNT_FINAL = CNT_W'(NUM_OSC - 1);

    logic [CNT_W-1:0] osc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_q <= '0;
        end else if (clear_i) begin
            osc_q <= '0;
        end else if (inc_i) begin
            osc_q <= osc_q + 1'b1;
        end
    end

    assign final_o = (osc_q == CNT_FINAL);
endmodule

// File: rtl/ovl_phase_guard.sv
// Measures how long the current switch phase has lasted; flags expiry.
module ovl_phase_guard #(
    parameter int TMO_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_i,
    input  logic dis_i,
    output logic expired_o
);
    localparam int TMO_W = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYCLES - 1);

    logic [1:0]       phase_q;
    logic [1:0]       phase_now;
    logic [TMO_W-1:0] run_q;
    logic [TMO_W-1:0] run_len;

    assign phase_now = {chg_i, dis_i};
    assign run_len   = (phase_now != phase_q) ? '0 : run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 2'b00;
            run_q   <= '0;
        end else begin
            phase_q <= phase_now;
            if (phase_now == 2'b00) begin
                run_q <= '0;
            end else if (run_len != TMO_LAST) begin
                run_q <= run_len + 1'b1;
            end else begin
                run_q <= run_len;
            end
        end
    end

    assign expired_o = (phase_now != 2'b00) && (run_len == TMO_LAST);
endmodule

// File: rtl/ovl_blank_fsm.sv
module ovl_blank_fsm
    import ovl_blank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovld_i,
    input  logic cap_hi_i,
    input  logic cap_lo_i,
    input  logic fix_last_i,
    input  logic osc_final_i,
    input  logic expired_i,
    output logic in_fixed_o,
    output logic in_idle_o,
    output logic osc_inc_o,
    output logic chg_on_o,
    output logic dis_on_o,
    output logic trip_o,
    output logic tmo_err_o
);
    blank_state_e state_q;
    blank_state_e state_d;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        if (!ovld_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_FIXED;
                end
                ST_FIXED: begin
                    if (fix_last_i) state_d = ST_CHARGE;
                end
                ST_CHARGE: begin
                    if (cap_hi_i) begin
                        state_d = osc_final_i ? ST_TRIP : ST_DISCHARGE;
                    end else if (expired_i) begin
                        state_d = ST_STUCK;
                    end
                end
                ST_DISCHARGE: begin
                    if (cap_lo_i) begin
                        state_d = ST_CHARGE;
                    end else if (expired_i) begin
                        state_d = ST_STUCK;
                    end
                end
                ST_TRIP:  state_d = ST_TRIP;
                ST_STUCK: state_d = ST_STUCK;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Moore outputs
    always_comb begin
        chg_on_o   = 1'b0;
        dis_on_o   = 1'b0;
        trip_o     = 1'b0;
        tmo_err_o  = 1'b0;
        in_fixed_o = 1'b0;
        in_idle_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:      in_idle_o  = 1'b1;
            ST_FIXED:     in_fixed_o = 1'b1;
            ST_CHARGE:    chg_on_o   = 1'b1;
            ST_DISCHARGE: dis_on_o   = 1'b1;
            ST_TRIP:      trip_o     = 1'b1;
            ST_STUCK:     tmo_err_o  = 1'b1;
            default:      in_idle_o  = 1'b1;
        endcase
    end

    assign osc_inc_o = chg_on_o && cap_hi_i && ovld_i;
endmodule

// File: rtl/ovl_blank_timer.sv
module ovl_blank_timer #(
    parameter int PH1_CYCLES = 4_000_000,
    parameter int NUM_OSC    = 256,
    parameter int TMO_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovld_i,
    input  logic cap_hi_i,
    input  logic cap_lo_i,
    output logic chg_on_o,
    output logic dis_on_o,
    output logic trip_o,
    output logic tmo_err_o
);
    logic in_fixed;
    logic in_idle;
    logic osc_inc;
    logic fix_last;
    logic osc_final;
    logic expired;

    ovl_fixed_delay #(.PH1_CYCLES(PH1_CYCLES)) u_fixed (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (in_fixed),
        .last_o (fix_last)
    );

    ovl_osc_counter #(.NUM_OSC(NUM_OSC)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (in_idle),
        .inc_i   (osc_inc),
        .final_o (osc_final)
    );

    ovl_phase_guard #(.TMO_CYCLES(TMO_CYCLES)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .chg_i     (chg_on_o),
        .dis_i     (dis_on_o),
        .expired_o (expired)
    );

    ovl_blank_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ovld_i      (ovld_i),
        .cap_hi_i    (cap_hi_i),
        .cap_lo_i    (cap_lo_i),
        .fix_last_i  (fix_last),
        .osc_final_i (osc_final),
        .expired_i   (expired),
        .in_fixed_o  (in_fixed),
        .in_idle_o   (in_idle),
        .osc_inc_o   (osc_inc),
        .chg_on_o    (chg_on_o),
        .dis_on_o    (dis_on_o),
        .trip_o      (trip_o),
        .tmo_err_o   (tmo_err_o)
    );
endmodule

// File: rtl/ovl_blank_checker.sv
module ovl_blank_checker (
    input logic clk,
    input logic rst_n,
    input logic ovld_i,
    input logic cap_hi_i,
    input logic cap_lo_i,
    input logic chg_on_o,
    input logic dis_on_o,
    input logic trip_o,
    input logic tmo_err_o
);
    assert_switch_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(chg_on_o && dis_on_o));

    assert_drop_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ovld_i |=> (!chg_on_o && !dis_on_o && !trip_o && !tmo_err_o));

    assert_trip_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_o && ovld_i) |=> trip_o);

    assert_charge_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_on_o && !cap_hi_i && ovld_i) |=> (chg_on_o || tmo_err_o));

    assert_charge_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_on_o && cap_hi_i && ovld_i) |=> (dis_on_o || trip_o));

    assert_discharge_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_on_o && !cap_lo_i && ovld_i) |=> (dis_on_o || tmo_err_o));

    assert_discharge_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_on_o && cap_lo_i && ovld_i) |=> chg_on_o);

    assert_trip_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip_o) |-> ($past(chg_on_o) && $past(cap_hi_i)));

    assert_error_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err_o |-> (!chg_on_o && !dis_on_o && !trip_o));

    assert_error_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_err_o && ovld_i) |=> tmo_err_o);
endmodule

bind ovl_blank_timer ovl_blank_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ovld_i    (ovld_i),
    .cap_hi_i  (cap_hi_i),
    .cap_lo_i  (cap_lo_i),
    .chg_on_o  (chg_on_o),
    .dis_on_o  (dis_on_o),
    .trip_o    (trip_o),
    .tmo_err_o (tmo_err_o)
);

// File: tb/test_ovl_blank_timer.sv
`timescale 1ns/1ps
module test_ovl_blank_timer;
    localparam int PH1 = 20;
    localparam int NOSC = 256;
    localparam int TMO = 40;
    localparam int HI_LV = 6;
    localparam int LO_LV = 1;

    // model state codes (bench only)
    localparam int M_IDLE = 0, M_FIX = 1, M_CHG = 2, M_DIS = 3, M_TRIP = 4, M_ERR = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovl = 1'b0;
    logic hi, lo;
    logic chg, dis, trip, err;

    int cap = 0;
    int step = 1;
    bit cap_ok = 1'b1;
    bit lo_dead = 1'b0;
    bit force_hi = 1'b0;

    int m_state = M_IDLE;
    int m_fix = 0;
    int m_cnt = 0;
    int m_run = 0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    assign hi = force_hi || (cap_ok && cap >= HI_LV);
    assign lo = cap_ok && !lo_dead && cap <= LO_LV;

    ovl_blank_timer #(.PH1_CYCLES(PH1), .NUM_OSC(NOSC), .TMO_CYCLES(TMO)) i_ovl_blank_timer (
        .clk(clk), .rst_n(rst_n), .ovld_i(ovl), .cap_hi_i(hi), .cap_lo_i(lo),
        .chg_on_o(chg), .dis_on_o(dis), .trip_o(trip), .tmo_err_o(err)
    );

    // Reference model: advances on each rising edge from the inputs held since the last falling edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_state = M_IDLE; m_cnt = 0; m_fix = 0; m_run = 0;
        end else if (!ovl) begin
            m_state = M_IDLE; m_cnt = 0;
        end else begin
            case (m_state)
                M_IDLE: begin m_state = M_FIX; m_fix = 0; end
                M_FIX: begin
                    if (m_fix == PH1 - 1) begin m_state = M_CHG; m_run = 0; end
                    else m_fix++;
                end
                M_CHG: begin
                    if (hi) begin
                        m_cnt++;
                        m_run = 0;
                        m_state = (m_cnt == NOSC) ? M_TRIP : M_DIS;
                    end else if (m_run == TMO - 1) m_state = M_ERR;
                    else m_run++;
                end
                M_DIS: begin
                    if (lo) begin m_state = M_CHG; m_run = 0; end
                    else if (m_run == TMO - 1) m_state = M_ERR;
                    else m_run++;
                end
                default: ;
            endcase
        end
    end

    function automatic string req_of(int s);
        case (s)
            M_FIX:  return "R2";
            M_CHG:  return "R3";
            M_DIS:  return "R4";
            M_TRIP: return "R5/R8";
            M_ERR:  return "R9";
            default: return "R7";
        endcase
    endfunction

    // Per-cycle comparison plus capacitor ramp, away from the rising edge
    always @(negedge clk) begin
        logic [3:0] exp_v, act_v;
        if (rst_n) begin
            exp_v = {m_state == M_CHG, m_state == M_DIS, m_state == M_TRIP, m_state == M_ERR};
            act_v = {chg, dis, trip, err};
            n_cmp++;
            if (exp_v !== act_v) begin
                n_bad++;
                $display("FAIL %s cyc=%0d {chg,dis,trip,err} actual=%b expected=%b",
                         req_of(m_state), cyc, act_v, exp_v);
            end
            n_cmp++;
            if (chg && dis) begin
                n_bad++;
                $display("FAIL R6 both switches on actual=11 expected=not 11");
            end
        end
        if (m_state == M_CHG) cap = (cap + step > 20) ? 20 : cap + step;
        else if (m_state == M_DIS) cap = (cap - step < 0) ? 0 : cap - step;
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_trip(input int limit);
        for (int i = 0; i < limit && !trip; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        #900000;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait_n(3);
        // R1: reset state
        check({chg, dis, trip, err} == 4'b0, "R1 reset outputs", {chg, dis, trip, err}, 0);
        rst_n = 1'b1;
        wait_n(3);
        check({chg, dis, trip, err} == 4'b0, "R1 idle outputs", {chg, dis, trip, err}, 0);

        // R2: exact fixed delay, R10: hi forced during it is ignored
        force_hi = 1'b1;
        ovl = 1'b1;
        wait_n(PH1);
        check(chg == 1'b0, "R2 R10 switches off at end of delay", chg, 0);
        force_hi = 1'b0;
        wait_n(1);
        check(chg == 1'b1, "R2 charge after delay", chg, 1);

        // R3/R4/R5: full oscillation run to trip, step 1
        wait_trip(20000);
        wait_n(1);
        check(trip == 1'b1, "R5 trip after NUM_OSC", trip, 1);
        check(!chg && !dis, "R5 switches off in trip", {chg, dis}, 0);
        // R8: trip held, R10: lo ignored outside discharge
        cap = 0;
        wait_n(30);
        check(trip == 1'b1, "R8 trip held", trip, 1);
        ovl = 1'b0;
        wait_n(1);
        check({chg, dis, trip, err} == 4'b0, "R7 trip clears on drop", {chg, dis, trip, err}, 0);

        // R7: short pulse inside the fixed delay
        ovl = 1'b1; wait_n(10); ovl = 1'b0; wait_n(3);
        check({chg, dis, trip, err} == 4'b0, "R7 short pulse", {chg, dis, trip, err}, 0);

        // R7: drop mid-oscillation, restart must redo the full sequence
        cap = 0; step = 2;
        ovl = 1'b1; wait_n(PH1 + 200); ovl = 1'b0; wait_n(2);
        check({chg, dis} == 2'b0, "R7 mid-run drop", {chg, dis}, 0);
        ovl = 1'b1;
        wait_n(PH1 + 300);
        check(trip == 1'b0, "R7 count cleared no early trip", trip, 0);
        wait_trip(20000);
        wait_n(1);
        check(trip == 1'b1, "R5 trip with faster ramp", trip, 1);
        ovl = 1'b0; wait_n(2);

        // R9: missing capacitor, charge never ends
        cap = 0; cap_ok = 1'b0; step = 1;
        ovl = 1'b1;
        wait_n(PH1 + TMO + 2);
        check(err == 1'b1 && trip == 1'b0, "R9 charge timeout", {err, trip}, 2);
        wait_n(20);
        check(err == 1'b1, "R9 error held", err, 1);
        ovl = 1'b0; wait_n(1);
        check(err == 1'b0, "R7 error clears on drop", err, 0);

        // R9: discharge never reaches lower threshold
        cap_ok = 1'b1; lo_dead = 1'b1; cap = 0;
        ovl = 1'b1;
        wait_n(PH1 + HI_LV + TMO + 5);
        check(err == 1'b1 && !dis, "R9 discharge timeout", {err, dis}, 2);
        ovl = 1'b0; lo_dead = 1'b0; wait_n(3);
        check({chg, dis, trip, err} == 4'b0, "R1 idle after recovery", {chg, dis, trip, err}, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule